// File: doc/BRIEF.md
# Memory BIST March Pattern Sequencer

This block is the algorithm engine of a memory self-test controller. A 6-bit pattern code picks a test algorithm. After a start pulse the engine walks through the march elements of that algorithm. At every address it issues each read or write of the element, one access per clock, and compares every read against the value it expects. An external address counter does the address walking. The engine tells it when to reload at the start of an element and in which direction, when to step, and whether the Y coordinate moves fastest. The counter returns a flag at the final address and the checkerboard parity of the current location.

The engine runs solid and checkerboard fills and reads, March C+, a read-write march and a read-write-read march, each in X-fast and Y-fast order. It also runs a composite go/no-go suite that chains checkerboard passes and a Y-fast read-write-read march. In the march notation "0" means the data seed and "1" means its bitwise inverse. A mismatch sets a sticky fail flag. Only the next accepted start clears it. Done stays high until that start.

The state machine has these states:
- IDLE: after reset.
- DECODE: checks the latched code.
- LOAD: the counter reload cycle before each element.
- ACCESS: one memory operation per cycle.
- DRAIN: lets the last read compare.
- DONE.

The transitions are named as follows:
- start: IDLE or DONE to DECODE.
- code ok: DECODE to LOAD.
- code bad: DECODE to DONE.
- go: LOAD to ACCESS.
- next element or next suite phase: ACCESS to LOAD.
- stay: ACCESS to ACCESS.
- algorithm end: ACCESS to DRAIN.
- finish: DRAIN to DONE.

Top module: `mbist_march_engine`

## Requirements
- R1: Supported codes are 0x00 write solid, 0x01 read solid, 0x02 write checkerboard, 0x03 read checkerboard, 0x04/0x0B March C+ X/Y-fast, 0x06/0x07 read-write march X/Y-fast, 0x08/0x09 read-write-read march X/Y-fast, and 0x3F go/no-go. Any other code (for example 0x05, 0x0A) makes no memory access and no counter reload, asserts done two cycles after the start edge, and sets fail.
- R2: Solid patterns use one element with one access per address. A write stores the seed and a read expects the seed.
- R3: Checkerboard patterns use the seed where cb_phase is 0 and the inverted seed where cb_phase is 1, with one access per address.
- R4: March C+ runs (w0) up, (r0,w1,r1) up, (r1,w0,r0) up, (r0,w1,r1) down, (r1,w0,r0) down, (r0) up. That gives 14 accesses per address and 6 counter reloads.
- R5: Read-write march runs (w0) up, (r0,w1) up, (r1,w0) down, (r0) up. That gives 6 accesses per address and 4 reloads.
- R6: Read-write-read march runs (w0) up, (r0,w1,r1) up, (r1,w0,r0) down, (r0) up. That gives 8 accesses per address and 4 reloads.
- R7: addr_yfast is 1 while a Y-fast code runs and during the final go/no-go phase, and 0 for X-fast codes.
- R8: Go/no-go runs write checkerboard, read checkerboard, write checkerboard and read checkerboard with the supplied seed. It then runs a Y-fast read-write-read march with seed 0x06. That gives 12 accesses per address and 8 reloads, and every word holds 0x06 at the end.
- R9: Read data arriving one cycle after a read is compared with the expected value. A mismatch sets fail, and fail stays set.
- R10: A start accepted in IDLE or DONE clears fail. A start while busy is ignored.
- R11: addr_clear is a single cycle with no access, and it comes before each element with addr_down giving the element direction. addr_step pulses only with the final operation at an address and only when addr_last is 0.
- R12: After reset done, fail and mem_en are 0. Done stays high with no memory access until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| pattern | input | 6 | Algorithm code |
| seed | input | DW | Data seed |
| addr_last | input | 1 | Counter is at the final address for its direction |
| cb_phase | input | 1 | Checkerboard parity of current address |
| addr_clear | output | 1 | Reload counter at the start end of the current direction |
| addr_step | output | 1 | Advance counter by one address |
| addr_down | output | 1 | Direction of current element (1 = descending) |
| addr_yfast | output | 1 | Y coordinate moves fastest |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| done | output | 1 | Algorithm finished |
| fail | output | 1 | Sticky mismatch or bad-code flag |

## Verification
Two things can fall in the same cycle: the compare of the final read of an element, and the counter reload for the next element. The same holds for the last read of an algorithm and the DRAIN cycle. To provoke this, the bench injects a stuck bit at address 15, the final address of ascending elements, and at address 0, the final address of descending ones. Each march algorithm then must end with fail set. A fault-free run of each algorithm must end with fail clear and the exact per-address access count and reload count. A start pulse in the middle of a run must leave those counts untouched.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        A_WSOL, A_RSOL, A_WCB, A_RCB, A_MCP, A_RWM, A_RWRM, A_BAD
    } algo_e;

    typedef struct packed {
        logic we;
        logic inv;
    } op_t;

    typedef struct packed {
        logic [1:0] nops;
        logic       down;
        logic       cb;
        op_t [2:0]  ops;
        logic       last;
    } elem_t;

    localparam op_t OP_W0 = 2'b10;
    localparam op_t OP_W1 = 2'b11;
    localparam op_t OP_R0 = 2'b00;
    localparam op_t OP_R1 = 2'b01;

    localparam int ELEM_W  = 3;
    localparam int OP_W    = 2;
    localparam int PHASE_W = 3;
    localparam int GNG_LAST_PHASE = 4;

    function automatic elem_t mk_elem(input logic [1:0] n, input logic dn,
                                      input logic cb, input op_t a,
                                      input op_t b, input op_t c,
                                      input logic lst);
        elem_t e;
        e.nops = n;
        e.down = dn;
        e.cb   = cb;
        e.ops  = {c, b, a};
        e.last = lst;
        return e;
    endfunction

endpackage

// File: rtl/mbist_code_decode.sv
module mbist_code_decode
    import mbist_pkg::*;
(
    input  logic [5:0]         code,
    input  logic [PHASE_W-1:0] phase,
    output algo_e              algo,
    output logic               yfast,
    output logic               fixed_seed,
    output logic               valid,
    output logic               gng,
    output logic               last_phase
);

    always_comb begin
        algo       = A_BAD;
        yfast      = 1'b0;
        fixed_seed = 1'b0;
        valid      = 1'b1;
        gng        = 1'b0;
        last_phase = 1'b1;
        case (code)
            6'h00: algo = A_WSOL;
            6'h01: algo = A_RSOL;
            6'h02: algo = A_WCB;
            6'h03: algo = A_RCB;
            6'h04: algo = A_MCP;
            6'h0B: begin algo = A_MCP;  yfast = 1'b1; end
            6'h06: algo = A_RWM;
            6'h07: begin algo = A_RWM;  yfast = 1'b1; end
            6'h08: algo = A_RWRM;
            6'h09: begin algo = A_RWRM; yfast = 1'b1; end
            6'h3F: begin
                gng        = 1'b1;
                last_phase = (phase == PHASE_W'(GNG_LAST_PHASE));
                case (phase)
                    3'd0, 3'd2: algo = A_WCB;
                    3'd1, 3'd3: algo = A_RCB;
                    default: begin
                        algo       = A_RWRM;
                        yfast      = 1'b1;
                        fixed_seed = 1'b1;
                    end
                endcase
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/mbist_elem_rom.sv
module mbist_elem_rom
    import mbist_pkg::*;
(
    input  algo_e             algo,
    input  logic [ELEM_W-1:0] idx,
    output elem_t             elem
);

    always_comb begin
        elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
        case (algo)
            A_WSOL: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_W0, OP_R0, OP_R0, 1'b1);
            A_RSOL: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
            A_WCB:  elem = mk_elem(2'd1, 1'b0, 1'b1, OP_W0, OP_R0, OP_R0, 1'b1);
            A_RCB:  elem = mk_elem(2'd1, 1'b0, 1'b1, OP_R0, OP_R0, OP_R0, 1'b1);
            A_MCP: begin
                case (idx)
                    3'd0: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_W0, OP_R0, OP_R0, 1'b0);
                    3'd1: elem = mk_elem(2'd3, 1'b0, 1'b0, OP_R0, OP_W1, OP_R1, 1'b0);
                    3'd2: elem = mk_elem(2'd3, 1'b0, 1'b0, OP_R1, OP_W0, OP_R0, 1'b0);
                    3'd3: elem = mk_elem(2'd3, 1'b1, 1'b0, OP_R0, OP_W1, OP_R1, 1'b0);
                    3'd4: elem = mk_elem(2'd3, 1'b1, 1'b0, OP_R1, OP_W0, OP_R0, 1'b0);
                    default: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
                endcase
            end
            A_RWM: begin
                case (idx)
                    3'd0: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_W0, OP_R0, OP_R0, 1'b0);
                    3'd1: elem = mk_elem(2'd2, 1'b0, 1'b0, OP_R0, OP_W1, OP_R0, 1'b0);
                    3'd2: elem = mk_elem(2'd2, 1'b1, 1'b0, OP_R1, OP_W0, OP_R0, 1'b0);
                    default: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
                endcase
            end
            A_RWRM: begin
                case (idx)
                    3'd0: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_W0, OP_R0, OP_R0, 1'b0);
                    3'd1: elem = mk_elem(2'd3, 1'b0, 1'b0, OP_R0, OP_W1, OP_R1, 1'b0);
                    3'd2: elem = mk_elem(2'd3, 1'b1, 1'b0, OP_R1, OP_W0, OP_R0, 1'b0);
                    default: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
                endcase
            end
            default: elem = mk_elem(2'd1, 1'b0, 1'b0, OP_R0, OP_R0, OP_R0, 1'b1);
        endcase
    end

endmodule

// File: rtl/mbist_rd_check.sv
module mbist_rd_check #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          set_err,
    input  logic          rd_issue,
    input  logic [DW-1:0] exp_in,
    input  logic [DW-1:0] rdata,
    output logic          fail
);

    logic          pend_q;
    logic [DW-1:0] exp_q;
    logic          mismatch;

    assign mismatch = pend_q && (rdata != exp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= '0;
            fail   <= 1'b0;
        end else begin
            pend_q <= rd_issue;
            if (rd_issue) exp_q <= exp_in;
            if (clear) fail <= 1'b0;
            else       fail <= fail | mismatch | set_err;
        end
    end

endmodule

// File: rtl/mbist_seq_fsm.sv
module mbist_seq_fsm
    import mbist_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               code_valid,
    input  logic               gng,
    input  logic               last_phase,
    input  logic [1:0]         nops,
    input  logic               elem_last,
    input  logic               addr_last,
    output logic [ELEM_W-1:0]  elem_idx,
    output logic [OP_W-1:0]    op_idx,
    output logic [PHASE_W-1:0] phase,
    output logic               mem_en,
    output logic               addr_clear,
    output logic               addr_step,
    output logic               done,
    output logic               busy,
    output logic               set_err,
    output logic               take
);

    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_LOAD, S_ACCESS, S_DRAIN, S_DONE
    } state_e;

    state_e state, nxt;
    logic   op_last;
    logic   more_phase;

    assign op_last    = (op_idx == (nops - 2'd1));
    assign more_phase = gng && !last_phase;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_DONE: if (start) nxt = S_DECODE;
            S_DECODE:       nxt = code_valid ? S_LOAD : S_DONE;
            S_LOAD:         nxt = S_ACCESS;
            S_ACCESS: begin
                if (op_last && addr_last) begin
                    if (elem_last && !more_phase) nxt = S_DRAIN;
                    else                          nxt = S_LOAD;
                end
            end
            S_DRAIN:        nxt = S_DONE;
            default:        nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            elem_idx <= '0;
            op_idx   <= '0;
            phase    <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        elem_idx <= '0;
                        op_idx   <= '0;
                        phase    <= '0;
                    end
                end
                S_ACCESS: begin
                    if (op_last) begin
                        op_idx <= '0;
                        if (addr_last) begin
                            if (!elem_last)      elem_idx <= elem_idx + 1'b1;
                            else if (more_phase) begin
                                elem_idx <= '0;
                                phase    <= phase + 1'b1;
                            end
                        end
                    end else begin
                        op_idx <= op_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_en     = (state == S_ACCESS);
        addr_clear = (state == S_LOAD);
        addr_step  = (state == S_ACCESS) && op_last && !addr_last;
        done       = (state == S_DONE);
        busy       = (state != S_IDLE) && (state != S_DONE);
        set_err    = (state == S_DECODE) && !code_valid;
        take       = start && ((state == S_IDLE) || (state == S_DONE));
    end

endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine
    import mbist_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [5:0]    pattern,
    input  logic [DW-1:0] seed,
    input  logic          addr_last,
    input  logic          cb_phase,
    output logic          addr_clear,
    output logic          addr_step,
    output logic          addr_down,
    output logic          addr_yfast,
    output logic          mem_en,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fail
);

    localparam logic [DW-1:0] GNG_SEED = DW'(6);

    logic [5:0]         code_q;
    logic [DW-1:0]      seed_q;
    logic [ELEM_W-1:0]  elem_idx;
    logic [OP_W-1:0]    op_idx;
    logic [PHASE_W-1:0] phase;
    algo_e              algo;
    logic               yfast, fixed_seed, code_valid, gng, last_phase;
    elem_t              elem;
    op_t                cur_op;
    logic               busy, set_err, take;
    logic [DW-1:0]      eff_seed, data;
    logic               flip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            seed_q <= '0;
        end else if (take) begin
            code_q <= pattern;
            seed_q <= seed;
        end
    end

    mbist_code_decode u_dec (
        .code       (code_q),
        .phase      (phase),
        .algo       (algo),
        .yfast      (yfast),
        .fixed_seed (fixed_seed),
        .valid      (code_valid),
        .gng        (gng),
        .last_phase (last_phase)
    );

    mbist_elem_rom u_rom (
        .algo (algo),
        .idx  (elem_idx),
        .elem (elem)
    );

    mbist_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .code_valid (code_valid),
        .gng        (gng),
        .last_phase (last_phase),
        .nops       (elem.nops),
        .elem_last  (elem.last),
        .addr_last  (addr_last),
        .elem_idx   (elem_idx),
        .op_idx     (op_idx),
        .phase      (phase),
        .mem_en     (mem_en),
        .addr_clear (addr_clear),
        .addr_step  (addr_step),
        .done       (done),
        .busy       (busy),
        .set_err    (set_err),
        .take       (take)
    );

    always_comb begin
        case (op_idx)
            2'd0:    cur_op = elem.ops[0];
            2'd1:    cur_op = elem.ops[1];
            default: cur_op = elem.ops[2];
        endcase
    end

    assign eff_seed   = fixed_seed ? GNG_SEED : seed_q;
    assign flip       = cur_op.inv ^ (elem.cb & cb_phase);
    assign data       = eff_seed ^ {DW{flip}};
    assign mem_we     = mem_en & cur_op.we;
    assign mem_wdata  = data;
    assign addr_down  = elem.down;
    assign addr_yfast = yfast;

    mbist_rd_check #(.DW(DW)) u_chk_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take),
        .set_err  (set_err),
        .rd_issue (mem_en & ~cur_op.we),
        .exp_in   (data),
        .rdata    (mem_rdata),
        .fail     (fail)
    );

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic fail,
    input logic mem_en,
    input logic addr_clear,
    input logic addr_step
);

    assert_clear_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clear |-> !mem_en);

    assert_clear_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clear |=> !addr_clear);

    assert_step_with_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |-> mem_en);

    assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_en && !busy));

    assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> fail);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !fail);

endmodule

bind mbist_march_engine mbist_march_chk u_march_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .mem_en     (mem_en),
    .addr_clear (addr_clear),
    .addr_step  (addr_step)
);

// File: tb/mbist_march_engine_bench.sv
`timescale 1ns/1ps
module mbist_march_engine_bench;

    localparam int DW = 8;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    pattern = '0;
    logic [DW-1:0] seed = '0;
    logic          addr_last, cb_phase;
    logic          addr_clear, addr_step, addr_down, addr_yfast;
    logic          mem_en, mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done, fail;

    always #2 clk = ~clk;

    mbist_march_engine #(.DW(DW)) u_mbist_march_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern), .seed(seed),
        .addr_last(addr_last), .cb_phase(cb_phase), .addr_clear(addr_clear),
        .addr_step(addr_step), .addr_down(addr_down), .addr_yfast(addr_yfast),
        .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .fail(fail)
    );

    // behavioural address counter: address = {cy, cx}
    logic [1:0] cx = 2'd0, cy = 2'd0;
    logic [3:0] addr;
    assign addr      = {cy, cx};
    assign addr_last = addr_down ? (cx == 2'd0 && cy == 2'd0) : (cx == 2'd3 && cy == 2'd3);
    assign cb_phase  = cx[0] ^ cy[0];

    always @(posedge clk) begin
        if (addr_clear) begin
            cx <= addr_down ? 2'd3 : 2'd0;
            cy <= addr_down ? 2'd3 : 2'd0;
        end else if (addr_step) begin
            if (addr_yfast) begin
                cy <= addr_down ? cy - 2'd1 : cy + 2'd1;
                if (cy == (addr_down ? 2'd0 : 2'd3)) cx <= addr_down ? cx - 2'd1 : cx + 2'd1;
            end else begin
                cx <= addr_down ? cx - 2'd1 : cx + 2'd1;
                if (cx == (addr_down ? 2'd0 : 2'd3)) cy <= addr_down ? cy - 2'd1 : cy + 2'd1;
            end
        end
    end

    // behavioural RAM with injectable stuck bit on reads
    logic [DW-1:0] ram [NW];
    int            cnt [NW];
    int            clr_cnt;
    logic          cnt_clr = 1'b0;
    logic          stuck_en = 1'b0;
    int            stuck_addr = 0;
    int            stuck_bit = 0;
    logic          stuck_val = 1'b0;

    function automatic logic [DW-1:0] faulty(input logic [DW-1:0] v, input int a);
        logic [DW-1:0] r;
        r = v;
        if (stuck_en && a == stuck_addr) r[stuck_bit] = stuck_val;
        return r;
    endfunction

    initial begin
        for (int i = 0; i < NW; i++) ram[i] = '0;
    end

    always @(posedge clk) begin
        if (cnt_clr) begin
            for (int i = 0; i < NW; i++) cnt[i] = 0;
            clr_cnt = 0;
        end else begin
            if (addr_clear) clr_cnt = clr_cnt + 1;
            if (mem_en) begin
                cnt[addr] = cnt[addr] + 1;
                if (mem_we) ram[addr] <= mem_wdata;
                else        mem_rdata <= faulty(ram[addr], int'(addr));
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        int    exp_cnt;
        int    exp_clr;
        bit    exp_fail;
        string tag;
    } item_t;
    item_t sbq[$];
    logic  done_q = 1'b0;

    always @(negedge clk) begin
        done_q <= done;
        if (done && !done_q && sbq.size() > 0) begin
            item_t it;
            int    badaddr;
            int    firstbad;
            it = sbq.pop_front();
            chk(fail == it.exp_fail, it.tag, "fail flag", int'(fail), int'(it.exp_fail));
            badaddr = 0;
            firstbad = it.exp_cnt;
            for (int i = 0; i < NW; i++) begin
                if (cnt[i] != it.exp_cnt) begin
                    if (badaddr == 0) firstbad = cnt[i];
                    badaddr++;
                end
            end
            chk(badaddr == 0, it.tag, "accesses per address", firstbad, it.exp_cnt);
            chk(clr_cnt == it.exp_clr, "R11", "counter reloads", clr_cnt, it.exp_clr);
        end
    end

    task automatic run(input logic [5:0] code, input logic [DW-1:0] sd,
                       input int ecnt, input int eclr, input bit efail,
                       input int yf, input bit poke, input string tag);
        item_t it;
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        it.exp_cnt = ecnt; it.exp_clr = eclr; it.exp_fail = efail; it.tag = tag;
        sbq.push_back(it);
        pattern = code;
        seed    = sd;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        chk(fail == 1'b0, "R10", "fail cleared by start", int'(fail), 0);
        repeat (6) @(negedge clk);
        if (yf >= 0) chk(int'(addr_yfast) == yf, "R7", "address order", int'(addr_yfast), yf);
        if (poke) begin
            pattern = 6'h05;
            start   = 1'b1;
            @(negedge clk);
            start   = 1'b0;
        end
        while (sbq.size() > 0) @(negedge clk);
    endtask

    task automatic check_ram(input logic [DW-1:0] even_v, input logic [DW-1:0] odd_v,
                             input string req);
        int nbad;
        int firstv;
        nbad = 0;
        firstv = int'(even_v);
        for (int a = 0; a < NW; a++) begin
            logic [DW-1:0] e;
            e = (a[0] ^ a[2]) ? odd_v : even_v;
            if (ram[a] !== e) begin
                if (nbad == 0) firstv = int'(ram[a]);
                nbad++;
            end
        end
        chk(nbad == 0, req, "memory contents", firstv, int'(even_v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && fail == 1'b0 && mem_en == 1'b0, "R12", "reset outputs",
            int'({done, fail, mem_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(6'h00, 8'hA5, 1, 1, 1'b0, -1, 1'b0, "R2");
        check_ram(8'hA5, 8'hA5, "R2");
        run(6'h01, 8'hA5, 1, 1, 1'b0, -1, 1'b0, "R2");
        run(6'h01, 8'h5A, 1, 1, 1'b1, -1, 1'b0, "R9");
        run(6'h05, 8'h00, 0, 0, 1'b1, -1, 1'b0, "R1");
        run(6'h0A, 8'h00, 0, 0, 1'b1, -1, 1'b0, "R1");
        run(6'h01, 8'hA5, 1, 1, 1'b0, -1, 1'b0, "R10");

        run(6'h02, 8'h3C, 1, 1, 1'b0, -1, 1'b0, "R3");
        check_ram(8'h3C, 8'hC3, "R3");
        run(6'h03, 8'h3C, 1, 1, 1'b0, -1, 1'b0, "R3");
        run(6'h01, 8'h3C, 1, 1, 1'b1, -1, 1'b0, "R3");

        run(6'h04, 8'h96, 14, 6, 1'b0, 0, 1'b0, "R4");
        check_ram(8'h96, 8'h96, "R4");
        run(6'h0B, 8'h96, 14, 6, 1'b0, 1, 1'b0, "R4");
        run(6'h06, 8'h33, 6, 4, 1'b0, 0, 1'b0, "R5");
        run(6'h07, 8'h33, 6, 4, 1'b0, 1, 1'b0, "R5");
        run(6'h08, 8'h0F, 8, 4, 1'b0, 0, 1'b0, "R6");
        run(6'h09, 8'h0F, 8, 4, 1'b0, 1, 1'b0, "R6");

        run(6'h3F, 8'h81, 12, 8, 1'b0, -1, 1'b0, "R8");
        check_ram(8'h06, 8'h06, "R8");

        run(6'h04, 8'h96, 14, 6, 1'b0, 0, 1'b1, "R10");

        stuck_en = 1'b1; stuck_addr = 15; stuck_bit = 2; stuck_val = 1'b1;
        run(6'h04, 8'h00, 14, 6, 1'b1, 0, 1'b0, "R9");
        run(6'h0B, 8'h00, 14, 6, 1'b1, 1, 1'b0, "R9");
        run(6'h06, 8'h00, 6, 4, 1'b1, 0, 1'b0, "R9");
        run(6'h09, 8'h00, 8, 4, 1'b1, 1, 1'b0, "R9");
        run(6'h3F, 8'hFB, 12, 8, 1'b1, -1, 1'b0, "R9");
        stuck_addr = 0; stuck_bit = 5; stuck_val = 1'b0;
        run(6'h04, 8'h00, 14, 6, 1'b1, 0, 1'b0, "R9");
        run(6'h07, 8'h00, 6, 4, 1'b1, 1, 1'b0, "R9");
        run(6'h08, 8'h00, 8, 4, 1'b1, 0, 1'b0, "R9");
        stuck_en = 1'b0;

        repeat (3) @(negedge clk);
        chk(done == 1'b1 && mem_en == 1'b0, "R12", "done held", int'({done, mem_en}), 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule